// File: doc/BRIEF.md
# Multi-port hardware mutex unit

This unit holds a bank of hardware locks that several processors share. Each processor talks to it through its own request port and reaches every lock in the bank. To take a lock, software writes the lock register with the lock bit set and its own CPU number. It then reads the register back and compares the owner fields with its own identity. To give the lock up, the owner writes the register with the lock bit clear. The hardware tags each owner with the port number and the bus master ID that took the lock. A release only succeeds when the CPU number and this hidden tag both match the stored owner.

Only one access reaches the lock bank in any cycle. A fixed-priority arbiter picks the lowest-numbered port that has a request pending, and every other port stalls. Requests use a valid/ready handshake. A port must hold `req_valid` and all of its request fields steady until it sees `req_ready`, and the transfer happens on that clock edge. The response cannot be held back. On the next cycle `rsp_valid` pulses for exactly one cycle on the port that was served, and the shared `rsp_data` bus carries the result. The requester must take it in that cycle.

Top module: `mutex_unit`

## Requirements
- R1: After reset every lock is released, all of its fields read as zero, and `req_ready` and `rsp_valid` are all low.
- R2: In each cycle at most one port sees `req_ready`, and only when its `req_valid` is high. A request accepted on a clock edge produces a one-cycle `rsp_valid` on the same port in the next cycle, and no other port sees `rsp_valid` then. The response data is zero for a write. A port that is not granted keeps waiting with no response.
- R3: When several ports request in the same cycle, the lowest-numbered port is granted. Whenever any request is pending, some port is granted.
- R4: The lock index is address bits [8 +: log2(NMUTEX)]. The register inside the 256-byte window of a lock is selected by address bits [7:2], where word 0 is the lock register. Address bits [1:0] are ignored.
- R5: A write to a released lock register with data bit 0 set locks it. The write stores data bits [CPUID_W:1] as the owner CPU number, and stores {port number as 3 bits, master ID} as the hidden owner tag.
- R6: A write with bit 0 set to a lock that is already held leaves all of its fields unchanged.
- R7: A read of the lock register returns the lock bit in bit 0, the owner CPU number in bits [CPUID_W:1], and the owner tag {port[2:0], master ID} in the bits just above, with zero in every higher bit.
- R8: A write with bit 0 clear releases a held lock when written bits [CPUID_W:1] equal the stored CPU number and the writer's {port, master ID} equals the stored tag. The release clears all fields to zero.
- R9: A release write with a wrong CPU number, from a different port, or with a different master ID leaves the lock held and unchanged.
- R10: Reads of any word other than word 0 in a lock's window return zero. Writes to those words change no lock.
- R11: A write to a lock register with any byte-enable bit clear changes nothing.
- R12: One access changes at most the one lock it addresses. Locks are independent of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORTS | Request pending, one bit per port |
| req_ready | output | NPORTS | Request accepted this cycle, one bit per port |
| req_write | input | NPORTS | 1 = write, 0 = read, per port |
| req_addr | input | NPORTS*ADDR_W | Byte address per port |
| req_wdata | input | NPORTS*DATA_W | Write data per port |
| req_be | input | NPORTS*(DATA_W/8) | Byte enables per port |
| req_mid | input | NPORTS*MID_W | Bus master ID per port |
| rsp_valid | output | NPORTS | One-cycle response strobe per port |
| rsp_data | output | DATA_W | Shared response data |

## Verification
A corrupted owner field or lock bit shows up on the first read-back of that lock. It appears as a wrong lock bit, CPU number or tag in `rsp_data` one cycle after the read is accepted. The fault can also show later, when a release that should work is refused or one that should fail succeeds. A wrong grant or priority shows at once in `req_ready` in the same cycle as the request, and in `rsp_valid` one cycle after. The bench keeps a shadow copy of every lock, so any divergence is caught at the next read of the affected lock.

// File: rtl/mutex_pkg.sv
package mutex_pkg;
  // bytes per lock window, as a bit count
  localparam int WIN_BITS  = 8;
  // width of the port number inside the owner tag
  localparam int PORT_ID_W = 3;

  typedef enum logic [0:0] {
    KIND_LOCK = 1'b0,
    KIND_NONE = 1'b1
  } reg_kind_e;

  function automatic reg_kind_e decode_kind(input logic [WIN_BITS-1:0] offs);
    return (offs[WIN_BITS-1:2] == '0) ? KIND_LOCK : KIND_NONE;
  endfunction
endpackage

// File: rtl/mutex_arbiter.sv
module mutex_arbiter #(
  parameter int NPORTS = 4
) (
  input  logic [NPORTS-1:0] req,
  output logic [NPORTS-1:0] gnt
);
  // lowest index wins: scan from the top so lower indices overwrite
  always_comb begin
    gnt = '0;
    for (int i = NPORTS - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mutex_req_mux.sv
module mutex_req_mux
  import mutex_pkg::*;
#(
  parameter int NPORTS = 4,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 32,
  parameter int MID_W  = 4,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic [NPORTS-1:0]        gnt,
  input  logic [NPORTS-1:0]        write,
  input  logic [NPORTS*ADDR_W-1:0] addr,
  input  logic [NPORTS*DATA_W-1:0] wdata,
  input  logic [NPORTS*BE_W-1:0]   be,
  input  logic [NPORTS*MID_W-1:0]  mid,
  output logic                     sel_write,
  output logic [ADDR_W-1:0]        sel_addr,
  output logic [DATA_W-1:0]        sel_wdata,
  output logic [BE_W-1:0]          sel_be,
  output logic [MID_W-1:0]         sel_mid,
  output logic [PORT_ID_W-1:0]     sel_port
);
  // one-hot AND-OR selection of the granted port's fields
  always_comb begin
    sel_write = 1'b0;
    sel_addr  = '0;
    sel_wdata = '0;
    sel_be    = '0;
    sel_mid   = '0;
    sel_port  = '0;
    for (int i = 0; i < NPORTS; i++) begin
      sel_write = sel_write | (gnt[i] & write[i]);
      sel_addr  = sel_addr  | ({ADDR_W{gnt[i]}} & addr[i*ADDR_W +: ADDR_W]);
      sel_wdata = sel_wdata | ({DATA_W{gnt[i]}} & wdata[i*DATA_W +: DATA_W]);
      sel_be    = sel_be    | ({BE_W{gnt[i]}}   & be[i*BE_W +: BE_W]);
      sel_mid   = sel_mid   | ({MID_W{gnt[i]}}  & mid[i*MID_W +: MID_W]);
      sel_port  = sel_port  | ({PORT_ID_W{gnt[i]}} & PORT_ID_W'(i));
    end
  end
endmodule

// File: rtl/mutex_store.sv
module mutex_store #(
  parameter int NMUTEX   = 8,
  parameter int DATA_W   = 32,
  parameter int CPUID_W  = 8,
  parameter int HW_W     = 7,
  localparam int IDX_W   = $clog2(NMUTEX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,     // accepted full-width write to a lock register
  input  logic [IDX_W-1:0]   idx,
  input  logic               wr_lock,   // written lock bit
  input  logic [CPUID_W-1:0] wr_cpu,
  input  logic [HW_W-1:0]    wr_tag,
  output logic [DATA_W-1:0]  rd_word,
  output logic [NMUTEX-1:0]  lock_vec
);
  logic [NMUTEX*CPUID_W-1:0] cpu_flat;
  logic [NMUTEX*HW_W-1:0]    tag_flat;

  for (genvar g = 0; g < NMUTEX; g++) begin : g_ent
    logic               lock_q;
    logic [CPUID_W-1:0] cpu_q;
    logic [HW_W-1:0]    tag_q;
    logic               hit, take, drop;

    assign hit  = wr_en && (idx == IDX_W'(g));
    assign take = hit && wr_lock && !lock_q;
    assign drop = hit && !wr_lock && lock_q && (wr_cpu == cpu_q) && (wr_tag == tag_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q <= 1'b0;
        cpu_q  <= '0;
        tag_q  <= '0;
      end else if (take) begin
        lock_q <= 1'b1;
        cpu_q  <= wr_cpu;
        tag_q  <= wr_tag;
      end else if (drop) begin
        lock_q <= 1'b0;
        cpu_q  <= '0;
        tag_q  <= '0;
      end
    end

    assign lock_vec[g]                    = lock_q;
    assign cpu_flat[g*CPUID_W +: CPUID_W] = cpu_q;
    assign tag_flat[g*HW_W +: HW_W]       = tag_q;
  end

  always_comb begin
    rd_word                     = '0;
    rd_word[0]                  = lock_vec[idx];
    rd_word[CPUID_W:1]          = cpu_flat[idx*CPUID_W +: CPUID_W];
    rd_word[CPUID_W+1 +: HW_W]  = tag_flat[idx*HW_W +: HW_W];
  end
endmodule

// File: rtl/mutex_unit.sv
module mutex_unit
  import mutex_pkg::*;
#(
  parameter int NPORTS   = 4,
  parameter int NMUTEX   = 8,
  parameter int DATA_W   = 32,
  parameter int MID_W    = 4,
  parameter int CPUID_W  = 8,
  localparam int IDX_W   = $clog2(NMUTEX),
  localparam int ADDR_W  = WIN_BITS + IDX_W,
  localparam int BE_W    = DATA_W / 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORTS-1:0]        req_valid,
  output logic [NPORTS-1:0]        req_ready,
  input  logic [NPORTS-1:0]        req_write,
  input  logic [NPORTS*ADDR_W-1:0] req_addr,
  input  logic [NPORTS*DATA_W-1:0] req_wdata,
  input  logic [NPORTS*BE_W-1:0]   req_be,
  input  logic [NPORTS*MID_W-1:0]  req_mid,
  output logic [NPORTS-1:0]        rsp_valid,
  output logic [DATA_W-1:0]        rsp_data
);
  localparam int HW_W = PORT_ID_W + MID_W;

  logic [NPORTS-1:0]    gnt;
  logic                 sel_write;
  logic [ADDR_W-1:0]    sel_addr;
  logic [DATA_W-1:0]    sel_wdata;
  logic [BE_W-1:0]      sel_be;
  logic [MID_W-1:0]     sel_mid;
  logic [PORT_ID_W-1:0] sel_port;
  logic                 acc, acc_wr, is_lock;
  logic [DATA_W-1:0]    rd_word;
  logic [NMUTEX-1:0]    lock_vec;
  logic [NPORTS-1:0]    rsp_valid_q;
  logic [DATA_W-1:0]    rsp_data_q;

  mutex_arbiter #(.NPORTS(NPORTS)) u_arb (
    .req (req_valid),
    .gnt (gnt)
  );

  mutex_req_mux #(
    .NPORTS(NPORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MID_W(MID_W)
  ) u_mux (
    .gnt       (gnt),
    .write     (req_write),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .be        (req_be),
    .mid       (req_mid),
    .sel_write (sel_write),
    .sel_addr  (sel_addr),
    .sel_wdata (sel_wdata),
    .sel_be    (sel_be),
    .sel_mid   (sel_mid),
    .sel_port  (sel_port)
  );

  assign acc     = |gnt;
  assign acc_wr  = acc && sel_write;
  assign is_lock = (decode_kind(sel_addr[WIN_BITS-1:0]) == KIND_LOCK);

  mutex_store #(
    .NMUTEX(NMUTEX), .DATA_W(DATA_W), .CPUID_W(CPUID_W), .HW_W(HW_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (acc_wr && is_lock && (&sel_be)),
    .idx      (sel_addr[WIN_BITS +: IDX_W]),
    .wr_lock  (sel_wdata[0]),
    .wr_cpu   (sel_wdata[CPUID_W:1]),
    .wr_tag   ({sel_port, sel_mid}),
    .rd_word  (rd_word),
    .lock_vec (lock_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= '0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= gnt;
      if (acc) rsp_data_q <= (!sel_write && is_lock) ? rd_word : '0;
    end
  end

  assign req_ready = gnt;
  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/mutex_unit_chk.sv
module mutex_unit_chk #(
  parameter int NPORTS = 4,
  parameter int NMUTEX = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] req_valid,
  input logic [NPORTS-1:0] req_ready,
  input logic [NPORTS-1:0] rsp_valid,
  input logic [NMUTEX-1:0] lock_vec,
  input logic              acc_wr
);
  p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  p_grant_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  // nothing below the granted port may be waiting; no grant means no request
  p_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_ready - NPORTS'(1)) & req_valid) == '0);

  p_resp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == ($past(req_ready) & {NPORTS{$past(rst_n)}}));

  p_lock_change_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_vec != $past(lock_vec)) |-> $past(acc_wr));

  p_one_lock_per_access_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_vec ^ $past(lock_vec)) <= 1);
endmodule

bind mutex_unit mutex_unit_chk #(.NPORTS(NPORTS), .NMUTEX(NMUTEX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .lock_vec  (lock_vec),
  .acc_wr    (acc_wr)
);

// File: tb/mutex_unit_tb.sv
`timescale 1ns/1ps
module mutex_unit_tb;
  localparam int NP = 4, NM = 8, DW = 32, MW = 4, CW = 8;
  localparam int AW = 8 + 3, BW = DW / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0]    req_valid = '0, req_write = '0;
  logic [NP-1:0]    req_ready, rsp_valid;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP*DW-1:0] req_wdata = '0;
  logic [NP*BW-1:0] req_be = '0;
  logic [NP*MW-1:0] req_mid = '0;
  logic [DW-1:0]    rsp_data;

  always #2.5 clk = ~clk;

  mutex_unit #(.NPORTS(NP), .NMUTEX(NM), .DATA_W(DW), .MID_W(MW), .CPUID_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .req_mid(req_mid), .rsp_valid(rsp_valid), .rsp_data(rsp_data));

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic          m_lock [NM];
  logic [CW-1:0] m_cpu  [NM];
  logic [6:0]    m_tag  [NM];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(input int m, input int offs);
    return {3'(m), 8'(offs)};
  endfunction

  function automatic logic [31:0] exp_word(input int m);
    return {16'h0, m_tag[m], m_cpu[m], m_lock[m]};
  endfunction

  function automatic void model_wr(input int p, input logic [AW-1:0] a, input logic [31:0] d,
                                   input logic [3:0] be, input logic [3:0] mid);
    int m = int'(a[10:8]);
    if (a[7:2] != 0 || be != 4'hF) return;
    if (d[0] && !m_lock[m]) begin
      m_lock[m] = 1'b1; m_cpu[m] = d[8:1]; m_tag[m] = {3'(p), mid};
    end else if (!d[0] && m_lock[m] && d[8:1] == m_cpu[m] && {3'(p), mid} == m_tag[m]) begin
      m_lock[m] = 1'b0; m_cpu[m] = '0; m_tag[m] = '0;
    end
  endfunction

  task automatic drive(input int p, input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [3:0] be, input logic [3:0] mid);
    req_write[p] = wr;
    req_addr[p*AW +: AW] = a;
    req_wdata[p*DW +: DW] = d;
    req_be[p*BW +: BW] = be;
    req_mid[p*MW +: MW] = mid;
    req_valid[p] = 1'b1;
  endtask

  task automatic acc(input int p, input bit wr, input logic [AW-1:0] a, input logic [31:0] d,
                     input logic [3:0] be, input logic [3:0] mid, output logic [31:0] rd);
    @(negedge clk);
    drive(p, wr, a, d, be, mid);
    #1;
    while (!req_ready[p]) begin
      @(negedge clk); #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid[p] = 1'b0;
    chk(rsp_valid == NP'(1 << p), "R2 response strobe", 32'(rsp_valid), 32'(1 << p));
    if (wr) chk(rsp_data == 0, "R2 write response data", rsp_data, 0);
    rd = rsp_data;
    if (wr) model_wr(p, a, d, be, mid);
  endtask

  task automatic rd_chk(input int p, input int m, input string tag);
    logic [31:0] r;
    acc(p, 1'b0, mk_addr(m, 0), 0, 4'hF, 0, r);
    chk(r == exp_word(m), tag, r, exp_word(m));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < NM; i++) begin m_lock[i] = 0; m_cpu[i] = 0; m_tag[i] = 0; end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0 && req_ready == 0, "R1 idle outputs in reset", 32'({req_ready, rsp_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 0, "R1 no response after reset", 32'(rsp_valid), 0);
    for (int m = 0; m < NM; m++) rd_chk(m % NP, m, "R1 lock released after reset");

    // R5 / R7: take lock 2 from port 1, master 5, CPU 0x3C
    acc(1, 1'b1, mk_addr(2, 0), {23'h0, 8'h3C, 1'b1}, 4'hF, 4'd5, r);
    acc(0, 1'b0, mk_addr(2, 0), 0, 4'hF, 0, r);
    chk(r == 32'h0000_2A79, "R5 R7 owner fields after lock", r, 32'h0000_2A79);
    // R6: second lock attempt ignored
    acc(2, 1'b1, mk_addr(2, 0), {23'h0, 8'h11, 1'b1}, 4'hF, 4'd1, r);
    rd_chk(3, 2, "R6 held lock unchanged");
    // R9: wrong CPU, wrong port, wrong master ID
    acc(1, 1'b1, mk_addr(2, 0), {23'h0, 8'h3D, 1'b0}, 4'hF, 4'd5, r);
    rd_chk(0, 2, "R9 wrong cpu release ignored");
    acc(0, 1'b1, mk_addr(2, 0), {23'h0, 8'h3C, 1'b0}, 4'hF, 4'd5, r);
    rd_chk(0, 2, "R9 wrong port release ignored");
    acc(1, 1'b1, mk_addr(2, 0), {23'h0, 8'h3C, 1'b0}, 4'hF, 4'd6, r);
    rd_chk(0, 2, "R9 wrong master release ignored");
    chk(exp_word(2) == 32'h0000_2A79, "R9 model still held", exp_word(2), 32'h0000_2A79);
    // R8: correct release
    acc(1, 1'b1, mk_addr(2, 0), {23'h0, 8'h3C, 1'b0}, 4'hF, 4'd5, r);
    acc(2, 1'b0, mk_addr(2, 0), 0, 4'hF, 0, r);
    chk(r == 0, "R8 release clears all fields", r, 0);
    // R11: partial byte enables
    acc(0, 1'b1, mk_addr(4, 0), {23'h0, 8'h22, 1'b1}, 4'h7, 4'd1, r);
    rd_chk(0, 4, "R11 partial write ignored");
    chk(exp_word(4) == 0, "R11 model stays released", exp_word(4), 0);
    // R10: other words
    acc(0, 1'b1, mk_addr(4, 4), 32'hFFFF_FFFF, 4'hF, 4'd1, r);
    acc(0, 1'b1, mk_addr(4, 8'h80), 32'hFFFF_FFFF, 4'hF, 4'd1, r);
    rd_chk(1, 4, "R10 writes to other words ignored");
    acc(0, 1'b1, mk_addr(4, 0), {23'h0, 8'h22, 1'b1}, 4'hF, 4'd1, r);
    acc(1, 1'b0, mk_addr(4, 4), 0, 4'hF, 0, r);
    chk(r == 0, "R10 user word reads zero", r, 0);
    acc(1, 1'b0, mk_addr(4, 8'hFC), 0, 4'hF, 0, r);
    chk(r == 0, "R10 reserved word reads zero", r, 0);
    // R4 / R12: low address bits ignored, neighbours untouched
    acc(3, 1'b1, mk_addr(5, 2), {23'h0, 8'h5A, 1'b1}, 4'hF, 4'd9, r);
    rd_chk(0, 5, "R4 low address bits ignored");
    chk(m_lock[5] == 1'b1, "R4 model locked", 32'(m_lock[5]), 1);
    rd_chk(0, 4, "R12 neighbour lock 4 unchanged");
    rd_chk(0, 6, "R12 neighbour lock 6 unchanged");

    // R3 / R2: all ports contend
    @(negedge clk);
    for (int p = 0; p < NP; p++) drive(p, 1'b0, mk_addr(5, 0), 0, 4'hF, 0);
    for (int k = 0; k < NP; k++) begin
      #1;
      chk(req_ready == NP'(1 << k), "R3 lowest port granted", 32'(req_ready), 32'(1 << k));
      @(posedge clk); @(negedge clk);
      chk(rsp_valid == NP'(1 << k), "R2 only served port responds", 32'(rsp_valid), 32'(1 << k));
      chk(rsp_data == exp_word(5), "R7 contended read data", rsp_data, exp_word(5));
      req_valid[k] = 1'b0;
    end
    // R3: ports 3 and 1 race for lock 6
    @(negedge clk);
    drive(3, 1'b1, mk_addr(6, 0), {23'h0, 8'h33, 1'b1}, 4'hF, 4'd2);
    drive(1, 1'b1, mk_addr(6, 0), {23'h0, 8'h11, 1'b1}, 4'hF, 4'd2);
    #1;
    chk(req_ready == 4'b0010, "R3 port 1 beats port 3", 32'(req_ready), 32'h2);
    @(posedge clk); @(negedge clk);
    req_valid[1] = 1'b0;
    model_wr(1, mk_addr(6, 0), {23'h0, 8'h11, 1'b1}, 4'hF, 4'd2);
    #1;
    chk(req_ready == 4'b1000, "R2 stalled port granted next", 32'(req_ready), 32'h8);
    @(posedge clk); @(negedge clk);
    req_valid[3] = 1'b0;
    model_wr(3, mk_addr(6, 0), {23'h0, 8'h33, 1'b1}, 4'hF, 4'd2);
    rd_chk(2, 6, "R3 race winner owns lock");
    chk(m_tag[6] == 7'h12, "R3 owner tag is port 1", 32'(m_tag[6]), 32'h12);

    // constrained random mix
    for (int n = 0; n < 500; n++) begin
      int p = $urandom_range(0, NP - 1);
      int m = $urandom_range(0, NM - 1);
      int kind = $urandom_range(0, 9);
      logic [3:0] mid = 4'($urandom_range(1, 2));
      logic [7:0] cpu = ($urandom_range(0, 1) != 0) ? 8'h10 : 8'h20;
      logic [3:0] be = ($urandom_range(0, 9) == 0) ? 4'h3 : 4'hF;
      if (kind <= 3) begin
        acc(p, 1'b1, mk_addr(m, $urandom_range(0, 3)), {23'h0, cpu, 1'b1}, be, mid, r);
      end else if (kind <= 6) begin
        if (m_lock[m] && $urandom_range(0, 1) != 0) begin
          p = int'(m_tag[m][6:4]); mid = m_tag[m][3:0];
          if ($urandom_range(0, 3) != 0) cpu = m_cpu[m];
        end
        acc(p, 1'b1, mk_addr(m, 0), {23'h0, cpu, 1'b0}, be, mid, r);
      end else if (kind <= 8) begin
        rd_chk(p, m, "R7 random read-back");
      end else begin
        acc(p, 1'b1, mk_addr(m, 4 * $urandom_range(1, 63)), 32'hFFFF_FFFF, 4'hF, mid, r);
      end
    end
    for (int m = 0; m < NM; m++) rd_chk(0, m, "R12 final sweep");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule